// File: doc/BRIEF.md
# Guarded Index/Data Register Port for a Graphics Controller

This block gives a host processor access to a graphics controller's register set through two 8-bit I/O ports. A write to the index port chooses a register; reads and writes on the data port then reach the register that the index names. Indices 0 to 8 hold the standard controller registers as plain storage. Indices 9 to 15 hold seven extended registers: the low-window bank offset, the high-window bank offset, a control register, three further extended registers and, last, a guard register.

The guard register protects extended indices 9 to 14 from stray writes. They take writes only while the guard's low three bits hold the key value 5. The guard itself can always be written. The bank offsets, the control register and the enable bit for the second window are driven out to the address-window translator that sits next to this block. The host can also write both ports in one 16-bit access: the low byte goes to the index and the high byte goes to the register that the new index selects.

Top module: `xport_top`

## Requirements
- R1: Synchronous active-high reset clears the index and every register to zero. The guard therefore starts engaged, and `bank_a`, `bank_b`, `ctrl` and `bank_b_en` read 0.
- R2: A read of the index port (`host_port`=0) returns the full 8-bit value last written to it, including values of 16 or above.
- R3: A data-port write (`host_port`=1) to an index from 0 to 8 stores the byte. Reading the data port with the same index returns that byte.
- R4: While the guard's low 3 bits differ from 5, data writes to indices 9 to 14 leave those registers unchanged.
- R5: A write to index 15 always stores the full byte, whatever the guard state. A value whose bits [2:0] equal 5 (for example 0xA5 or 0x0D) releases the guard.
- R6: While the guard is released, writes to indices 9 to 14 take effect on the next clock. Index 9 drives `bank_a`, index 10 drives `bank_b` and index 11 drives `ctrl`.
- R7: `bank_b_en` equals bit 3 of the register at index 11. A read-modify-write that sets that bit, or clears it with mask 0xF7, leaves the other bits intact.
- R8: Data-port reads of indices 9 to 15 return the stored value while the guard is engaged.
- R9: An index of 16 or above selects no register. Data writes through it change nothing, and data-port reads return 0.
- R10: A write with `host_wide`=1 at the index port loads `host_wdata[7:0]` into the index and, on the same clock, writes `host_wdata[15:8]` to the register that the new index selects. This write obeys the guard as in R4. With `host_port`=1, `host_wide` is ignored and only the low byte is used.
- R11: Writing a guard value whose low bits differ from 5 re-engages the guard. Later writes to indices 9 to 14 are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_port | input | 1 | 0 = index port, 1 = data port |
| host_wide | input | 1 | 16-bit access: index in low byte, data in high byte |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 8 | Read value of the port chosen by `host_port` (combinational) |
| bank_a | output | 8 | Low-window bank offset (index 9) |
| bank_b | output | 8 | High-window bank offset (index 10) |
| ctrl | output | 8 | Extended control register (index 11) |
| bank_b_en | output | 1 | Second-window enable, bit 3 of `ctrl` |

## Verification
The assertions assume that `host_wr` is a single-cycle strobe and that `host_port`, `host_wide` and `host_wdata` are stable around the clock edge on which it is sampled. They also assume that reset is held for at least one edge before the first access. The bench drives every input on the falling edge and holds the strobe for exactly one rising edge. It samples `host_rdata` only after it has settled, so each write lands on a single, known edge. Stimulus includes index values of 16 and 255 as well as guard values that carry the key in their low bits with other high bits set. This exercises the out-of-range path and the modulo-8 key compare.

// File: rtl/xport_pkg.sv
package xport_pkg;

    localparam int DW         = 8;
    localparam int STD_CNT    = 9;
    localparam int EXT_CNT    = 7;
    localparam int EXT_BASE   = STD_CNT;
    localparam int SLOT_CNT   = STD_CNT + EXT_CNT;
    localparam int GUARD_IDX  = EXT_BASE + EXT_CNT - 1;
    localparam int KEY_W      = 3;
    localparam int KEY_VAL    = 5;
    localparam int BANKB_BIT  = 3;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic {
        PORT_INDEX = 1'b0,
        PORT_DATA  = 1'b1
    } port_e;

    typedef struct packed {
        logic  we;
        byte_t sel;
        byte_t val;
    } wr_req_t;

    function automatic logic key_opens(byte_t v);
        return v[KEY_W-1:0] == KEY_W'(KEY_VAL);
    endfunction

    function automatic logic in_range(byte_t s);
        return s < byte_t'(SLOT_CNT);
    endfunction

    function automatic logic is_guarded(byte_t s);
        return (s >= byte_t'(EXT_BASE)) && (s < byte_t'(GUARD_IDX));
    endfunction

endpackage

// File: rtl/xport_index.sv
module xport_index
    import xport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  idx_we,
    input  byte_t idx_wd,
    output byte_t idx_q
);

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (idx_we)
            idx_q <= idx_wd;
    end

    p_index_echo_r2: assert property (@(posedge clk) disable iff (rst)
        idx_we |=> idx_q == $past(idx_wd));

endmodule

// File: rtl/xport_route.sv
module xport_route
    import xport_pkg::*;
(
    input  logic        host_wr,
    input  logic        host_port,
    input  logic        host_wide,
    input  logic [15:0] host_wdata,
    input  byte_t       idx_q,
    output logic        idx_we,
    output byte_t       idx_wd,
    output wr_req_t     req
);

    port_e port;
    assign port = port_e'(host_port);

    always_comb begin
        idx_we  = host_wr && (port == PORT_INDEX);
        idx_wd  = host_wdata[DW-1:0];
        req.we  = 1'b0;
        req.sel = idx_q;
        req.val = host_wdata[DW-1:0];
        if (host_wr) begin
            if (port == PORT_DATA) begin
                req.we = 1'b1;
            end else if (host_wide) begin
                req.we  = 1'b1;
                req.sel = host_wdata[DW-1:0];
                req.val = host_wdata[2*DW-1:DW];
            end
        end
    end

endmodule

// File: rtl/xport_regs.sv
module xport_regs
    import xport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  byte_t   rd_sel,
    output byte_t   rd_val,
    output byte_t   bank_a,
    output byte_t   bank_b,
    output byte_t   ctrl
);

    byte_t std_q [STD_CNT];
    byte_t ext_q [EXT_CNT];
    logic  unlocked;

    assign unlocked = key_opens(ext_q[EXT_CNT-1]);

    for (genvar g = 0; g < STD_CNT; g++) begin : g_std
        always_ff @(posedge clk) begin
            if (rst)
                std_q[g] <= '0;
            else if (req.we && req.sel == byte_t'(g))
                std_q[g] <= req.val;
        end
    end

    for (genvar g = 0; g < EXT_CNT; g++) begin : g_ext
        localparam bit IS_GUARD = (g == EXT_CNT - 1);
        logic open;
        assign open = IS_GUARD ? 1'b1 : unlocked;
        always_ff @(posedge clk) begin
            if (rst)
                ext_q[g] <= '0;
            else if (req.we && open && req.sel == byte_t'(EXT_BASE + g))
                ext_q[g] <= req.val;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < STD_CNT; i++)
            if (rd_sel == byte_t'(i)) rd_val = std_q[i];
        for (int i = 0; i < EXT_CNT; i++)
            if (rd_sel == byte_t'(EXT_BASE + i)) rd_val = ext_q[i];
    end

    assign bank_a = ext_q[0];
    assign bank_b = ext_q[1];
    assign ctrl   = ext_q[2];

    // Flattened views used only by the properties below
    logic [(EXT_CNT-1)*DW-1:0] prot_flat;
    logic [SLOT_CNT*DW-1:0]    all_flat;
    always_comb begin
        for (int i = 0; i < EXT_CNT - 1; i++)
            prot_flat[i*DW +: DW] = ext_q[i];
        for (int i = 0; i < STD_CNT; i++)
            all_flat[i*DW +: DW] = std_q[i];
        for (int i = 0; i < EXT_CNT; i++)
            all_flat[(STD_CNT+i)*DW +: DW] = ext_q[i];
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> all_flat == '0);

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (req.we && !unlocked && is_guarded(req.sel)) |=> $stable(prot_flat));

    p_guard_write_r5: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == byte_t'(GUARD_IDX)) |=> ext_q[EXT_CNT-1] == $past(req.val));

    p_open_write_r6: assert property (@(posedge clk) disable iff (rst)
        (req.we && unlocked && req.sel == byte_t'(EXT_BASE)) |=> bank_a == $past(req.val));

    p_no_slot_r9: assert property (@(posedge clk) disable iff (rst)
        (req.we && !in_range(req.sel)) |=> $stable(all_flat));

endmodule

// File: rtl/xport_top.sv
module xport_top
    import xport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_port,
    input  logic        host_wide,
    input  logic [15:0] host_wdata,
    output logic [7:0]  host_rdata,
    output logic [7:0]  bank_a,
    output logic [7:0]  bank_b,
    output logic [7:0]  ctrl,
    output logic        bank_b_en
);

    byte_t   idx_q;
    byte_t   idx_wd;
    logic    idx_we;
    wr_req_t req;
    byte_t   rd_val;

    xport_route u_route (
        .host_wr    (host_wr),
        .host_port  (host_port),
        .host_wide  (host_wide),
        .host_wdata (host_wdata),
        .idx_q      (idx_q),
        .idx_we     (idx_we),
        .idx_wd     (idx_wd),
        .req        (req)
    );

    xport_index u_index (
        .clk    (clk),
        .rst    (rst),
        .idx_we (idx_we),
        .idx_wd (idx_wd),
        .idx_q  (idx_q)
    );

    xport_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .rd_sel (idx_q),
        .rd_val (rd_val),
        .bank_a (bank_a),
        .bank_b (bank_b),
        .ctrl   (ctrl)
    );

    assign host_rdata = (port_e'(host_port) == PORT_INDEX) ? idx_q : rd_val;
    assign bank_b_en  = ctrl[BANKB_BIT];

    p_wide_index_r10: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_port && host_wide) |=> idx_q == $past(host_wdata[7:0]));

endmodule

// File: tb/xport_top_test.sv
module xport_top_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_port = 1'b0;
    logic        host_wide = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  bank_a;
    logic [7:0]  bank_b;
    logic [7:0]  ctrl;
    logic        bank_b_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xport_top uut (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_port  (host_port),
        .host_wide  (host_wide),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .bank_a     (bank_a),
        .bank_b     (bank_b),
        .ctrl       (ctrl),
        .bank_b_en  (bank_b_en)
    );

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic put(logic port, logic wide, logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_port = port; host_wide = wide; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wide = 1'b0; host_wdata = '0;
    endtask

    task automatic set_index(logic [7:0] i);  put(1'b0, 1'b0, {8'h00, i}); endtask
    task automatic put_data(logic [7:0] d);   put(1'b1, 1'b0, {8'h00, d}); endtask
    task automatic put_reg(logic [7:0] i, logic [7:0] d); set_index(i); put_data(d); endtask

    task automatic get(logic port, output logic [7:0] v);
        host_port = port;
        #1 v = host_rdata;
    endtask

    task automatic get_reg(logic [7:0] i, output logic [7:0] v);
        set_index(i);
        get(1'b1, v);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        get(1'b0, v);
        check8("R1 index", v, 8'h00);
        check8("R1 bank_a", bank_a, 8'h00);
        check8("R1 bank_b", bank_b, 8'h00);
        check8("R1 ctrl", ctrl, 8'h00);
        check8("R1 bank_b_en", {7'd0, bank_b_en}, 8'h00);
        get_reg(8'h0F, v);
        check8("R1 guard", v, 8'h00);
    endtask

    task automatic t_index_echo;
        logic [7:0] v;
        set_index(8'h7E);
        get(1'b0, v);
        check8("R2 echo", v, 8'h7E);
    endtask

    task automatic t_standard;
        logic [7:0] v;
        put_reg(8'h03, 8'h5A);
        put_reg(8'h08, 8'hC3);
        get_reg(8'h03, v);
        check8("R3 std3", v, 8'h5A);
        get_reg(8'h08, v);
        check8("R3 std8", v, 8'hC3);
    endtask

    task automatic t_locked;
        put_reg(8'h09, 8'h12);
        put_reg(8'h0A, 8'h34);
        check8("R4 bank_a locked", bank_a, 8'h00);
        check8("R4 bank_b locked", bank_b, 8'h00);
    endtask

    task automatic t_unlock_and_banks;
        logic [7:0] v;
        put_reg(8'h0F, 8'hA5);
        get(1'b1, v);
        check8("R5 guard readback", v, 8'hA5);
        put_reg(8'h09, 8'h12);
        put_reg(8'h0A, 8'h2E);
        check8("R6 bank_a", bank_a, 8'h12);
        check8("R6 bank_b", bank_b, 8'h2E);
    endtask

    task automatic t_ctrl_rmw;
        logic [7:0] v;
        put_reg(8'h0B, 8'h41);
        get(1'b1, v);
        put_data(v | 8'h08);
        check8("R7 ctrl set", ctrl, 8'h49);
        check8("R7 en set", {7'd0, bank_b_en}, 8'h01);
        get(1'b1, v);
        put_data(v & 8'hF7);
        check8("R7 ctrl clear", ctrl, 8'h41);
        check8("R7 en clear", {7'd0, bank_b_en}, 8'h00);
    endtask

    task automatic t_wide;
        logic [7:0] v;
        put(1'b0, 1'b1, 16'h330A);
        get(1'b0, v);
        check8("R10 wide index", v, 8'h0A);
        check8("R10 wide bank_b", bank_b, 8'h33);
        put(1'b1, 1'b1, 16'h7766);
        check8("R10 data port wide", bank_b, 8'h66);
    endtask

    task automatic t_relock;
        logic [7:0] v;
        put_reg(8'h0F, 8'h00);
        put_reg(8'h09, 8'h77);
        check8("R11 relocked bank_a", bank_a, 8'h12);
        get_reg(8'h09, v);
        check8("R8 locked read", v, 8'h12);
        get_reg(8'h0F, v);
        check8("R8 guard read", v, 8'h00);
        put(1'b0, 1'b1, 16'h990A);
        check8("R10 wide locked", bank_b, 8'h66);
    endtask

    task automatic t_no_slot;
        logic [7:0] v;
        put_reg(8'h10, 8'h44);
        get(1'b1, v);
        check8("R9 read 0x10", v, 8'h00);
        set_index(8'hFF);
        get(1'b1, v);
        check8("R9 read 0xFF", v, 8'h00);
        get(1'b0, v);
        check8("R2 echo 0xFF", v, 8'hFF);
        get_reg(8'h00, v);
        check8("R9 std0 untouched", v, 8'h00);
        get_reg(8'h03, v);
        check8("R9 std3 untouched", v, 8'h5A);
    endtask

    task automatic t_guard_while_locked;
        logic [7:0] v;
        put_reg(8'h0F, 8'h0D);
        put_reg(8'h0E, 8'h66);
        get(1'b1, v);
        check8("R5 modulo key unlock", v, 8'h66);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_index_echo();
        t_standard();
        t_locked();
        t_unlock_and_banks();
        t_ctrl_rmw();
        t_wide();
        t_relock();
        t_no_slot();
        t_guard_while_locked();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule